// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial clock waveform for an I2C bus master from the functional clock. A programmable prescaler turns the functional clock into an internal tick. Two timing words then set how many ticks the clock spends low and high. The low phase always adds 7 ticks to its programmed count, and the high phase always adds 5. The full clock period is therefore (prescale + 1) × (low count + 7 + high count + 5) functional clocks.

Each timing word holds two 8-bit counts. The standard-rate count sits in the lower byte and the high-speed count in the upper byte. A mode select picks which byte is in effect. Some working points:

| Functional clock | Prescale | Low count | High count | SCL rate |
|---|---|---|---|---|
| 48 MHz | 1 | 111 | 117 | 100 kHz |
| 48 MHz | 1 | 23 | 25 | 400 kHz |
| 48 MHz | 1 | 5 | 7 | 1 MHz |
| 96 MHz | 23 | 13 | 15 | 100 kHz |
| 96 MHz | 9 | 5 | 7 | 400 kHz |

Besides the clock level, the block gives a neighbouring bit engine three signals: the internal tick, a strobe where data may change, and a strobe in the middle of the high phase where data is sampled. It also presents the computed period divisor, so software can report the bus rate.

Settings are captured only at phase boundaries and at start-up. A phase that has begun is never shortened or stretched by a reprogramming.

Top module: `scg_scl_gen`

## Requirements
- R1: While the enable is low, and after reset, the SCL output is 1 and the tick, change strobe and sample strobe are all 0.
- R2: While running, the tick output pulses for one cycle every (prescale + 1) functional clocks.
- R3: The low phase lasts (prescale + 1) × (low count + 7) functional clocks. The high phase lasts (prescale + 1) × (high count + 5) functional clocks.
- R4: With the mode select at 0, the counts come from bits [7:0] of the two timing words. With the mode select at 1, they come from bits [15:8].
- R5: On the first clock edge that samples the enable high after it was low, SCL goes to 0, and a full low phase follows.
- R6: A new prescale, count or mode value applied in the middle of a phase first affects the next phase. The current phase keeps its length.
- R7: The change strobe is high for exactly one cycle, in the first cycle of every low phase, including the first low phase after the enable rises.
- R8: The sample strobe is high for exactly one cycle. It is due floor((high count + 5) / 2) × (prescale + 1) functional clocks after SCL rises, and it always coincides with a tick.
- R9: The divisor output equals (prescale + 1) × (low length + high length) for the settings in effect. While disabled, it follows the inputs one cycle later.
- R10: On the first clock edge that samples the enable low, SCL returns to 1 and all activity stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_en | input | 1 | Run enable |
| psc_val | input | 8 | Prescale value; the tick period is psc_val + 1 clocks |
| tlow_cfg | input | 16 | Low timing word: [7:0] standard count, [15:8] high-speed count |
| thigh_cfg | input | 16 | High timing word: [7:0] standard count, [15:8] high-speed count |
| hs_sel | input | 1 | 1 selects the upper-byte counts |
| samp_tick | output | 1 | One-cycle internal tick |
| scl_out | output | 1 | SCL drive level |
| chg_pt | output | 1 | Data change strobe at the start of a low phase |
| smp_pt | output | 1 | Data sample strobe at the middle of a high phase |
| rate_div | output | 19 | Period divisor in functional clocks |

## Verification
All outputs are registered.

The SCL level and the change strobe respond on the edge that samples a change of the enable, so they are due one cycle after it. A phase length is measured between two SCL transitions seen by the monitor. The sample strobe is timed from the SCL rise, and the divisor is read one cycle after an idle-time input change.

The driver applies inputs 2 ns after the rising edge and reads its direct checks at the same point. The monitor samples only on falling edges. Each SCL edge and each sample strobe pops one expected item, whose kind and cycle count are compared, so a shift of a single cycle in any phase shows as a mismatch.

// File: rtl/scg_pkg.sv
package scg_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scg_phase_e;
endpackage

// File: rtl/scg_cfg_select.sv
module scg_cfg_select #(
    parameter int CNT_W    = 8,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5,
    localparam int LEN_W   = CNT_W + 1
) (
    input  logic [2*CNT_W-1:0] low_word,
    input  logic [2*CNT_W-1:0] high_word,
    input  logic               hs_sel,
    output logic [LEN_W-1:0]   low_len,
    output logic [LEN_W-1:0]   high_len
);
    logic [CNT_W-1:0] low_cnt;
    logic [CNT_W-1:0] high_cnt;

    // Pick the byte lane for the active speed mode.
    always_comb begin
        if (hs_sel) begin
            low_cnt  = low_word[2*CNT_W-1:CNT_W];
            high_cnt = high_word[2*CNT_W-1:CNT_W];
        end else begin
            low_cnt  = low_word[CNT_W-1:0];
            high_cnt = high_word[CNT_W-1:0];
        end
    end

    // Add the fixed per-phase offsets.
    assign low_len  = LEN_W'(low_cnt)  + LEN_W'(LOW_OFS);
    assign high_len = LEN_W'(high_cnt) + LEN_W'(HIGH_OFS);
endmodule

// File: rtl/scg_prescaler.sv
module scg_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] limit,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_state_t;

    psc_state_t st_d, st_q;

    // The tick is raised on the last count of each prescale window.
    assign tick = run && (st_q.cnt == limit);

    always_comb begin
        st_d = st_q;
        if (!run || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PSC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/scg_phase_seq.sv
module scg_phase_seq
    import scg_pkg::*;
#(
    parameter int PSC_W    = 8,
    parameter int LEN_W    = 9,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic [PSC_W-1:0] psc_in,
    input  logic [LEN_W-1:0] low_len_in,
    input  logic [LEN_W-1:0] high_len_in,
    output logic             active,
    output logic [PSC_W-1:0] psc_sh,
    output logic [LEN_W-1:0] low_len_sh,
    output logic [LEN_W-1:0] high_len_sh,
    output logic             scl,
    output logic             tick_o,
    output logic             chg,
    output logic             smp
);
    typedef struct packed {
        logic             active;
        scg_phase_e       phase;
        logic [LEN_W-1:0] ph_cnt;
        logic [PSC_W-1:0] psc;
        logic [LEN_W-1:0] low_len;
        logic [LEN_W-1:0] high_len;
        logic             scl;
        logic             tick_o;
        logic             chg;
        logic             smp;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [LEN_W-1:0] cur_len;
    logic [LEN_W-1:0] cnt_inc;
    logic             last_tick;
    logic             mid_high;

    assign cur_len   = (st_q.phase == PH_HIGH) ? st_q.high_len : st_q.low_len;
    assign cnt_inc   = st_q.ph_cnt + LEN_W'(1);
    assign last_tick = (st_q.ph_cnt == (cur_len - LEN_W'(1)));
    assign mid_high  = (st_q.phase == PH_HIGH) && (cnt_inc == (st_q.high_len >> 1));

    always_comb begin
        st_d        = st_q;
        st_d.tick_o = 1'b0;
        st_d.chg    = 1'b0;
        st_d.smp    = 1'b0;

        if (!en) begin
            // Idle: SCL released; shadows track the inputs.
            st_d.active   = 1'b0;
            st_d.phase    = PH_LOW;
            st_d.ph_cnt   = '0;
            st_d.scl      = 1'b1;
            st_d.psc      = psc_in;
            st_d.low_len  = low_len_in;
            st_d.high_len = high_len_in;
        end else if (!st_q.active) begin
            // First enabled edge: open a low phase.
            st_d.active   = 1'b1;
            st_d.phase    = PH_LOW;
            st_d.ph_cnt   = '0;
            st_d.scl      = 1'b0;
            st_d.chg      = 1'b1;
            st_d.psc      = psc_in;
            st_d.low_len  = low_len_in;
            st_d.high_len = high_len_in;
        end else if (tick) begin
            st_d.tick_o = 1'b1;
            if (last_tick) begin
                // Phase boundary: capture new settings and flip.
                st_d.ph_cnt   = '0;
                st_d.psc      = psc_in;
                st_d.low_len  = low_len_in;
                st_d.high_len = high_len_in;
                if (st_q.phase == PH_LOW) begin
                    st_d.phase = PH_HIGH;
                    st_d.scl   = 1'b1;
                end else begin
                    st_d.phase = PH_LOW;
                    st_d.scl   = 1'b0;
                    st_d.chg   = 1'b1;
                end
            end else begin
                st_d.ph_cnt = cnt_inc;
                st_d.smp    = mid_high;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active   <= 1'b0;
            st_q.phase    <= PH_LOW;
            st_q.ph_cnt   <= '0;
            st_q.psc      <= '0;
            st_q.low_len  <= LEN_W'(LOW_OFS);
            st_q.high_len <= LEN_W'(HIGH_OFS);
            st_q.scl      <= 1'b1;
            st_q.tick_o   <= 1'b0;
            st_q.chg      <= 1'b0;
            st_q.smp      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active      = st_q.active;
    assign psc_sh      = st_q.psc;
    assign low_len_sh  = st_q.low_len;
    assign high_len_sh = st_q.high_len;
    assign scl         = st_q.scl;
    assign tick_o      = st_q.tick_o;
    assign chg         = st_q.chg;
    assign smp         = st_q.smp;
endmodule

// File: rtl/scg_div_calc.sv
module scg_div_calc #(
    parameter int PSC_W  = 8,
    parameter int LEN_W  = 9,
    localparam int DIV_W = PSC_W + LEN_W + 2
) (
    input  logic [PSC_W-1:0] psc,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    output logic [DIV_W-1:0] div
);
    logic [PSC_W:0] psc_p1;
    logic [LEN_W:0] len_sum;

    assign psc_p1  = {1'b0, psc} + (PSC_W+1)'(1);
    assign len_sum = {1'b0, low_len} + {1'b0, high_len};
    assign div     = DIV_W'(psc_p1) * DIV_W'(len_sum);
endmodule

// File: rtl/scg_scl_gen.sv
module scg_scl_gen #(
    parameter int PSC_W    = 8,
    parameter int CNT_W    = 8,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_en,
    input  logic [PSC_W-1:0]         psc_val,
    input  logic [2*CNT_W-1:0]       tlow_cfg,
    input  logic [2*CNT_W-1:0]       thigh_cfg,
    input  logic                     hs_sel,
    output logic                     samp_tick,
    output logic                     scl_out,
    output logic                     chg_pt,
    output logic                     smp_pt,
    output logic [PSC_W+CNT_W+2:0]   rate_div
);
    localparam int LEN_W = CNT_W + 1;

    logic [LEN_W-1:0] low_len_in, high_len_in;
    logic [LEN_W-1:0] low_len_sh, high_len_sh;
    logic [PSC_W-1:0] psc_sh;
    logic             run;
    logic             tick;

    scg_cfg_select #(
        .CNT_W(CNT_W), .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS)
    ) u_sel (
        .low_word (tlow_cfg),
        .high_word(thigh_cfg),
        .hs_sel   (hs_sel),
        .low_len  (low_len_in),
        .high_len (high_len_in)
    );

    scg_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .limit(psc_sh),
        .tick (tick)
    );

    scg_phase_seq #(
        .PSC_W(PSC_W), .LEN_W(LEN_W), .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (scl_en),
        .tick       (tick),
        .psc_in     (psc_val),
        .low_len_in (low_len_in),
        .high_len_in(high_len_in),
        .active     (run),
        .psc_sh     (psc_sh),
        .low_len_sh (low_len_sh),
        .high_len_sh(high_len_sh),
        .scl        (scl_out),
        .tick_o     (samp_tick),
        .chg        (chg_pt),
        .smp        (smp_pt)
    );

    scg_div_calc #(.PSC_W(PSC_W), .LEN_W(LEN_W)) u_div (
        .psc     (psc_sh),
        .low_len (low_len_sh),
        .high_len(high_len_sh),
        .div     (rate_div)
    );
endmodule

// File: rtl/scg_scl_gen_chk.sv
module scg_scl_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_en,
    input logic samp_tick,
    input logic scl_out,
    input logic chg_pt,
    input logic smp_pt
);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(scl_en) |-> (scl_out && !samp_tick && !chg_pt && !smp_pt));

    p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_en) |=> !scl_out);

    p_fall_marked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_out) |-> chg_pt);

    p_chg_in_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        chg_pt |-> !scl_out);

    p_smp_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        smp_pt |-> (scl_out && samp_tick));

    p_stop_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_en) |=> scl_out);
endmodule

bind scg_scl_gen scg_scl_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_en   (scl_en),
    .samp_tick(samp_tick),
    .scl_out  (scl_out),
    .chg_pt   (chg_pt),
    .smp_pt   (smp_pt)
);

// File: tb/scg_scl_gen_tb.sv
module scg_scl_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_en = 1'b0;
    logic [7:0]  psc_val = '0;
    logic [15:0] tlow_cfg = '0;
    logic [15:0] thigh_cfg = '0;
    logic        hs_sel = 1'b0;
    logic        samp_tick, scl_out, chg_pt, smp_pt;
    logic [18:0] rate_div;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    typedef struct {
        int kind;   // 0 low length, 1 high length, 2 sample offset
        int val;
    } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    scg_scl_gen u_dut (
        .clk(clk), .rst_n(rst_n), .scl_en(scl_en), .psc_val(psc_val),
        .tlow_cfg(tlow_cfg), .thigh_cfg(thigh_cfg), .hs_sel(hs_sel),
        .samp_tick(samp_tick), .scl_out(scl_out), .chg_pt(chg_pt),
        .smp_pt(smp_pt), .rate_div(rate_div)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: p prescale+1, l/h phase lengths in ticks.
    task automatic push_period(input int p, input int l, input int h);
        exp_q.push_back('{0, p * l});
        exp_q.push_back('{2, (h / 2) * p});
        exp_q.push_back('{1, p * h});
    endtask

    // Monitor: pops an expected item on every SCL edge and sample strobe.
    bit in_run = 0;
    bit prev_scl = 1;
    int edge_cyc = 0;

    task automatic pop_cmp(input int kind, input int val);
        item_t it;
        if (exp_q.size() == 0) begin
            chk(0, "R3 unexpected event", kind, -1);
        end else begin
            it = exp_q.pop_front();
            chk(it.kind == kind, "R3/R8 event order", kind, it.kind);
            if (kind == 2)
                chk(val == it.val, "R8 sample offset", val, it.val);
            else if (kind == 0)
                chk(val == it.val, "R3 R6 low length", val, it.val);
            else
                chk(val == it.val, "R3 R6 high length", val, it.val);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n || !scl_en) begin
            in_run = 0;
        end else begin
            if (prev_scl && !scl_out) begin
                if (in_run) pop_cmp(1, cyc - edge_cyc);
                chk(chg_pt == 1'b1, "R7 change strobe at fall", chg_pt, 1);
                in_run = 1;
                edge_cyc = cyc;
            end else if (!prev_scl && scl_out && in_run) begin
                pop_cmp(0, cyc - edge_cyc);
                edge_cyc = cyc;
            end else if (chg_pt) begin
                chk(0, "R7 stray change strobe", 1, 0);
            end
            if (smp_pt && in_run) pop_cmp(2, cyc - edge_cyc);
        end
        prev_scl = scl_out;
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic cfg(input int p, input int lc, input int hc, input bit hs);
        step();
        psc_val   = 8'(p);
        tlow_cfg  = 16'(lc);
        thigh_cfg = 16'(hc);
        hs_sel    = hs;
    endtask

    task automatic chk_div(input int exp);
        step();
        chk(rate_div == 19'(exp), "R9 divisor", int'(rate_div), exp);
    endtask

    task automatic start_run();
        step();
        scl_en = 1'b1;
        step();
        chk(scl_out == 1'b0, "R5 SCL low after enable", scl_out, 0);
        chk(chg_pt == 1'b1, "R7 change strobe on first low", chg_pt, 1);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) step();
    endtask

    task automatic stop_run();
        step();
        scl_en = 1'b0;
        step();
        chk(scl_out == 1'b1 && !samp_tick, "R10 stopped and released", scl_out, 1);
    endtask

    task automatic tick_gap(input int p);
        int t0;
        while (!samp_tick) step();
        t0 = cyc;
        step();
        while (!samp_tick) step();
        chk(cyc - t0 == p, "R2 tick spacing", cyc - t0, p);
    endtask

    bit finished = 0;

    initial begin
        int rises;
        bit last;
        bit idle_ok;
        repeat (3) step();
        chk(scl_out == 1'b1 && !samp_tick && !chg_pt && !smp_pt, "R1 reset state", scl_out, 1);
        rst_n = 1'b1;
        idle_ok = 1;
        for (int i = 0; i < 20; i++) begin
            step();
            if (!scl_out || samp_tick || chg_pt || smp_pt) idle_ok = 0;
        end
        chk(idle_ok, "R1 idle while disabled", idle_ok, 1);

        // Minimum lengths, prescale 0
        cfg(0, 0, 0, 0);
        chk_div(12);
        repeat (3) push_period(1, 7, 5);
        start_run();
        tick_gap(1);
        drain();
        stop_run();

        // 48 MHz / 1 MHz point
        cfg(1, 5, 7, 0);
        chk_div(48);
        repeat (3) push_period(2, 12, 12);
        start_run();
        tick_gap(2);
        drain();
        stop_run();

        // Asymmetric, prescale 3
        cfg(3, 2, 9, 0);
        chk_div(92);
        repeat (2) push_period(4, 9, 14);
        start_run();
        tick_gap(4);
        drain();
        stop_run();

        // R4: upper bytes in high-speed mode, lower bytes otherwise
        cfg(1, 16'h0305, 16'h0407, 1);
        chk_div(38);
        repeat (2) push_period(2, 10, 9);
        start_run();
        drain();
        stop_run();
        cfg(1, 16'h0305, 16'h0407, 0);
        chk_div(48);

        // R6: reprogram during the second high phase
        cfg(1, 5, 7, 0);
        repeat (2) push_period(2, 12, 12);
        repeat (2) push_period(1, 9, 6);
        start_run();
        rises = 0;
        last = scl_out;
        while (rises < 2) begin
            step();
            if (!last && scl_out) rises++;
            last = scl_out;
        end
        cfg(0, 2, 1, 0);
        drain();
        stop_run();

        // 100 kHz points
        cfg(1, 111, 117, 0);
        chk_div(480);
        push_period(2, 118, 122);
        start_run();
        drain();
        stop_run();

        cfg(23, 13, 15, 0);
        chk_div(960);
        push_period(24, 20, 20);
        start_run();
        drain();
        stop_run();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule